// File: doc/BRIEF.md
# External Data Access Router

This block sits between a processor core and the outside world and handles every move to or from the 64 KiB external data space. Each request carries a 16-bit address, a direction, write data and a pointer kind: an 8-bit register pointer or a 16-bit data pointer. From a mode bit and the address, the block decides whether the access goes to a 256-byte RAM held inside the block or out over a multiplexed pin bus.

When the mode bit `ext_only_i` is low, the on-chip RAM takes the place of the lowest 256 bytes of external space. Every 8-bit pointer access and every 16-bit pointer access below 0100h is then served inside the block in one cycle, and the pins do not move. When the mode bit is high, the on-chip RAM is hidden and every access runs an external bus cycle.

An external cycle has three parts. First comes an address phase with the latch enable high. Then the latch enable falls while the address is still held. Last comes a data phase with the read or write strobe held low for a fixed number of clocks. A busy/done pair tells the requester when the access is over.

Top module: `xdata_router`

## Requirements
- R1: During reset and after it, `busy_o`, `done_o`, `ale_o` and `p0_oe_o` are 0, `rd_no` and `wr_no` are 1, and `p0_o` and `p2_o` are FFh.
- R2: With `ext_only_i`=0 and `ptr16_i`=0, the access goes to on-chip RAM location `addr_i[7:0]`. `addr_i[15:8]` has no effect.
- R3: With `ext_only_i`=0 and `ptr16_i`=1, an address of 0000h–00FFh goes to the same on-chip RAM location that an 8-bit pointer with that low byte reaches.
- R4: An on-chip access raises `done_o` for the cycle after the request, and `busy_o` stays 0. In that cycle `p0_o`, `p2_o`, `p0_oe_o` and `ale_o` keep their values and both strobes stay high. A read returns the byte on `rdata_o` in that cycle.
- R5: With `ext_only_i`=0 and `ptr16_i`=1, an address of 0100h–FFFFh runs an external bus cycle.
- R6: With `ext_only_i`=1, every access runs an external bus cycle, and the on-chip RAM is neither read nor written.
- R7: In an external 16-bit pointer access, `p2_o` carries `addr_i[15:8]` and `p0_o` carries `addr_i[7:0]` with `p0_oe_o`=1 from the cycle after acceptance until the data phase.
- R8: In an external 8-bit pointer access, `p0_o` carries `addr_i[7:0]` and `p2_o` keeps the value left by the previous access, so it acts as a page register.
- R9: An external access accepted at edge k has `ale_o`=1 in cycle k+1, `ale_o`=0 with the address held in cycle k+2, and the strobe low in cycles k+3 to k+2+STROBE_CYCLES. In the next cycle the strobes are high, `done_o`=1 and `busy_o`=0. `busy_o` is 1 from k+1 until then.
- R10: A read lowers `rd_no` with `p0_oe_o`=0, samples `p0_i` on the last strobe cycle and returns it on `rdata_o` while `done_o` is high. A write lowers `wr_no` with `p0_o` = `wdata_i` and `p0_oe_o`=1.
- R11: A request while `busy_o`=1 is ignored. A request held high is taken again in the cycle where `done_o` is high.
- R12: `rd_no` and `wr_no` are never low together, and both are high while `ale_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_only_i | input | 1 | 1: on-chip RAM hidden, everything external |
| req_i | input | 1 | Access request, taken when `busy_o` is 0 |
| ptr16_i | input | 1 | 1: 16-bit data pointer, 0: 8-bit register pointer |
| addr_i | input | 16 | Access address |
| we_i | input | 1 | 1: write, 0: read |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | External cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid while `done_o` is high after a read |
| p0_o | output | 8 | Multiplexed low address / data out |
| p0_oe_o | output | 1 | Output enable for `p0_o` |
| p0_i | input | 8 | Data in from the multiplexed bus |
| p2_o | output | 8 | High address byte / page |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
Two events can fall in the same cycle: the completion of an external access (`done_o` high, strobes rising, write data still on `p0_o`) and the acceptance of the next request. That next request may be on-chip, which must leave the pins frozen at their completion values, or external, which must start a new address phase at once. The bench holds `req_i` high across whole external cycles and mixes on-chip and external requests at random. A behavioural frame-queue model predicts every pin on every clock, and a bench RAM that latches on the falling `ale_o` judges whether back-to-back accesses reach the correct addresses.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_HOLD,
    BUS_DATA
  } bus_state_e;
endpackage

// File: rtl/xdr_decode.sv
module xdr_decode #(
  parameter int AW      = 16,
  parameter int XRAM_AW = 8
) (
  input  logic          ext_only_i,
  input  logic          ptr16_i,
  input  logic [AW-1:0] addr_i,
  output logic          to_ram_o,
  output logic          to_bus_o
);
  logic hi_zero;
  assign hi_zero  = (addr_i[AW-1:XRAM_AW] == '0);
  // 8-bit pointer ignores the high byte; 16-bit pointer hits RAM only in the low window
  assign to_ram_o = !ext_only_i && (!ptr16_i || hi_zero);
  assign to_bus_o = !to_ram_o;
endmodule

// File: rtl/xdr_xram.sv
module xdr_xram #(
  parameter int DW = 8,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (en_i && !we_i)   rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/xdr_bus_seq.sv
module xdr_bus_seq
  import xdr_pkg::*;
#(
  parameter int DW            = 8,
  parameter int AW            = 16,
  parameter int STROBE_CYCLES = 3,
  localparam int HW    = AW - DW,
  localparam int CNT_W = $clog2(STROBE_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic          ptr16_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] p0_i,
  output logic [DW-1:0] p0_o,
  output logic          p0_oe_o,
  output logic [HW-1:0] p2_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYCLES - 1);

  bus_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             we_q;
  logic [DW-1:0]    wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUS_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      p0_o    <= '1;
      p0_oe_o <= 1'b0;
      p2_o    <= '1;
      ale_o   <= 1'b0;
      rd_no   <= 1'b1;
      wr_no   <= 1'b1;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        BUS_IDLE: begin
          if (start_i) begin
            state_q <= BUS_ADDR;
            we_q    <= we_i;
            wdata_q <= wdata_i;
            p0_o    <= addr_i[DW-1:0];
            p0_oe_o <= 1'b1;
            if (ptr16_i) p2_o <= addr_i[AW-1:DW];
            ale_o   <= 1'b1;
            busy_o  <= 1'b1;
          end
        end
        BUS_ADDR: begin
          state_q <= BUS_HOLD;
          ale_o   <= 1'b0;
        end
        BUS_HOLD: begin
          state_q <= BUS_DATA;
          cnt_q   <= CNT_LAST;
          rd_no   <= we_q;
          wr_no   <= !we_q;
          p0_oe_o <= we_q;
          if (we_q) p0_o <= wdata_q;
        end
        BUS_DATA: begin
          if (cnt_q == '0) begin
            state_q <= BUS_IDLE;
            rd_no   <= 1'b1;
            wr_no   <= 1'b1;
            p0_oe_o <= 1'b0;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            if (!we_q) rdata_o <= p0_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= BUS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int DW            = 8,
  parameter int AW            = 16,
  parameter int XRAM_AW       = 8,
  parameter int STROBE_CYCLES = 3,
  localparam int HW = AW - DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_only_i,
  input  logic          req_i,
  input  logic          ptr16_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] p0_o,
  output logic          p0_oe_o,
  input  logic [DW-1:0] p0_i,
  output logic [HW-1:0] p2_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no
);
  logic          to_ram, to_bus, accept;
  logic          ram_en, bus_start;
  logic          ram_done_q, src_bus_q;
  logic          bus_done;
  logic [DW-1:0] ram_rdata, bus_rdata;

  xdr_decode #(.AW(AW), .XRAM_AW(XRAM_AW)) u_decode (
    .ext_only_i (ext_only_i),
    .ptr16_i    (ptr16_i),
    .addr_i     (addr_i),
    .to_ram_o   (to_ram),
    .to_bus_o   (to_bus)
  );

  assign accept    = req_i && !busy_o;
  assign ram_en    = accept && to_ram;
  assign bus_start = accept && to_bus;

  xdr_xram #(.DW(DW), .AW(XRAM_AW)) u_xram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ram_en),
    .we_i    (we_i),
    .addr_i  (addr_i[XRAM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  xdr_bus_seq #(.DW(DW), .AW(AW), .STROBE_CYCLES(STROBE_CYCLES)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bus_start),
    .we_i    (we_i),
    .ptr16_i (ptr16_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .p0_i    (p0_i),
    .p0_o    (p0_o),
    .p0_oe_o (p0_oe_o),
    .p2_o    (p2_o),
    .ale_o   (ale_o),
    .rd_no   (rd_no),
    .wr_no   (wr_no),
    .busy_o  (busy_o),
    .done_o  (bus_done),
    .rdata_o (bus_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_done_q <= 1'b0;
      src_bus_q  <= 1'b0;
    end else begin
      ram_done_q <= ram_en;
      if (accept) src_bus_q <= to_bus;
    end
  end

  assign done_o  = ram_done_q || bus_done;
  assign rdata_o = src_bus_q ? bus_rdata : ram_rdata;
endmodule

// File: rtl/xdata_router_chk.sv
module xdata_router_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ext_only_i,
  input logic        req_i,
  input logic        ptr16_i,
  input logic [15:0] addr_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [7:0]  p0_o,
  input logic        p0_oe_o,
  input logic [7:0]  p2_o,
  input logic        ale_o,
  input logic        rd_no,
  input logic        wr_no
);
  logic take_ram, take_bus;
  assign take_ram = req_i && !busy_o && !ext_only_i && (!ptr16_i || addr_i[15:8] == 8'h00);
  assign take_bus = req_i && !busy_o && !take_ram;

  a_r4_onchip_pins_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_ram |=> ($stable(p0_o) && $stable(p2_o) && $stable(p0_oe_o)
                  && !ale_o && rd_no && wr_no && done_o && !busy_o));

  a_r5_bus_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_bus |=> (busy_o && ale_o && p0_oe_o));

  a_r8_page_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_bus && !ptr16_i) |=> $stable(p2_o));

  a_r9_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r10_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !p0_oe_o);

  a_r11_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !ale_o) |=> !ale_o);

  a_r12_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  a_r12_ale_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no));
endmodule

bind xdata_router xdata_router_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_only_i (ext_only_i),
  .req_i      (req_i),
  .ptr16_i    (ptr16_i),
  .addr_i     (addr_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .p0_o       (p0_o),
  .p0_oe_o    (p0_oe_o),
  .p2_o       (p2_o),
  .ale_o      (ale_o),
  .rd_no      (rd_no),
  .wr_no      (wr_no)
);

// File: tb/tb_xdata_router.sv
module tb_xdata_router;
  localparam int STROBE = 3;

  typedef struct packed {
    logic       ale;
    logic [7:0] p0;
    logic       oe;
    logic [7:0] p2;
    logic       rd_n;
    logic       wr_n;
    logic       busy;
    logic       done;
    logic       rvalid;
    logic [7:0] rdata;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_only = 1'b0, req = 1'b0, ptr16 = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, done, p0_oe, ale, rd_n, wr_n;
  logic [7:0]  rdata, p0_out, p2_out, p0_in;

  int tests = 0, fails = 0;
  bit finished = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  xdata_router #(.STROBE_CYCLES(STROBE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_only_i(ext_only), .req_i(req),
    .ptr16_i(ptr16), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .p0_o(p0_out), .p0_oe_o(p0_oe), .p0_i(p0_in), .p2_o(p2_out),
    .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n)
  );

  // external latch-based RAM
  logic [7:0]  env_mem [0:65535];
  logic [15:0] lat_addr = '0;
  always @(negedge ale) lat_addr = {p2_out, p0_out};
  always @(posedge wr_n) if (rst_ni) env_mem[lat_addr] = p0_out;
  assign p0_in = !rd_n ? env_mem[lat_addr] : 8'h00;

  // reference model
  logic [7:0] mdl_ext  [0:65535];
  logic [7:0] mdl_xram [0:255];
  frame_t     q[$];
  frame_t     cur;

  function automatic frame_t reset_frame();
    frame_t f;
    f = '0;
    f.p0 = 8'hFF; f.p2 = 8'hFF; f.rd_n = 1'b1; f.wr_n = 1'b1;
    return f;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] act %h exp %h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic compare(input frame_t e);
    chk("R9 ale", {7'd0, ale}, {7'd0, e.ale});
    chk("R7 p0", p0_out, e.p0);
    chk("R10 p0_oe", {7'd0, p0_oe}, {7'd0, e.oe});
    chk("R8 p2", p2_out, e.p2);
    chk("R10 rd_n", {7'd0, rd_n}, {7'd0, e.rd_n});
    chk("R10 wr_n", {7'd0, wr_n}, {7'd0, e.wr_n});
    chk("R11 busy", {7'd0, busy}, {7'd0, e.busy});
    chk("R4 done", {7'd0, done}, {7'd0, e.done});
    chk("R12 strobes", {7'd0, (!rd_n && !wr_n)}, 8'd0);
    if (e.done && e.rvalid) chk("R2 rdata", rdata, e.rdata);
  endtask

  task automatic step();
    frame_t nxt;
    bit on_chip;
    if (q.size() != 0) nxt = q.pop_front();
    else begin
      nxt = cur;
      nxt.ale = 0; nxt.oe = 0; nxt.rd_n = 1; nxt.wr_n = 1;
      nxt.busy = 0; nxt.done = 0; nxt.rvalid = 0;
    end
    if (req && !cur.busy) begin
      on_chip = !ext_only && (!ptr16 || addr[15:8] == 8'h00);
      if (on_chip) begin
        nxt.done = 1;
        nxt.rvalid = !we;
        if (we) mdl_xram[addr[7:0]] = wdata;
        else nxt.rdata = mdl_xram[addr[7:0]];
      end else begin
        frame_t f;
        logic [15:0] ea;
        f = nxt;
        f.ale = 1; f.p0 = addr[7:0]; f.oe = 1; f.busy = 1; f.done = 0; f.rvalid = 0;
        if (ptr16) f.p2 = addr[15:8];
        ea = {f.p2, addr[7:0]};
        nxt = f;
        f.ale = 0;
        q.push_back(f);
        for (int i = 0; i < STROBE; i++) begin
          f.rd_n = we; f.wr_n = !we; f.oe = we;
          if (we) f.p0 = wdata;
          q.push_back(f);
        end
        f.rd_n = 1; f.wr_n = 1; f.oe = 0; f.busy = 0; f.done = 1; f.rvalid = !we;
        if (we) mdl_ext[ea] = wdata;
        else f.rdata = mdl_ext[ea];
        q.push_back(f);
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(nxt);
    cur = nxt;
  endtask

  task automatic access(input logic eo, input logic p16, input logic [15:0] a,
                        input logic w, input logic [7:0] d);
    ext_only = eo; ptr16 = p16; addr = a; we = w; wdata = d; req = 1;
    step();
    req = 0;
    while (cur.busy) step();
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) begin
      env_mem[i] = 8'(i * 7 + (i >> 8) + 3);
      mdl_ext[i] = env_mem[i];
    end
    cur = reset_frame();
    @(negedge clk);
    // R1: reset state
    phase = "R1";
    compare(cur);
    @(negedge clk);
    rst_ni = 1;
    step();

    phase = "R3";  // fill on-chip RAM via 16-bit pointer, back-to-back
    for (int i = 0; i < 256; i++) access(0, 1, 16'(i), 1, 8'(i ^ 8'h5A));

    phase = "R2";  // 8-bit pointer ignores high byte
    access(0, 0, 16'h1234, 1, 8'hA5);
    access(0, 1, 16'h0034, 0, 8'h00);
    access(0, 0, 16'h77FF, 0, 8'h00);

    phase = "R5";  // 16-bit above window goes external
    access(0, 1, 16'h0100, 1, 8'h3C);
    access(0, 1, 16'h0100, 0, 8'h00);
    phase = "R10";
    access(0, 1, 16'hBEEF, 0, 8'h00);
    access(0, 1, 16'hFFFF, 1, 8'hC3);
    access(0, 1, 16'hFFFF, 0, 8'h00);

    phase = "R6";  // on-chip hidden: write goes out, RAM keeps A5
    access(1, 1, 16'h0034, 1, 8'h11);
    access(1, 1, 16'h0034, 0, 8'h00);
    access(0, 1, 16'h0034, 0, 8'h00);
    access(1, 0, 16'h0042, 0, 8'h00);

    phase = "R8";  // paging through port 2
    access(1, 1, 16'hAB00, 1, 8'h01);
    access(1, 0, 16'h0010, 1, 8'h77);
    access(1, 0, 16'hCD10, 0, 8'h00);
    access(1, 1, 16'hAB10, 0, 8'h00);

    phase = "R11";  // request held across external cycles, then on-chip
    ext_only = 0; ptr16 = 1; addr = 16'h4321; we = 0; req = 1;
    repeat (20) step();
    addr = 16'h0021;
    repeat (3) step();
    ptr16 = 0; addr = 16'h9921; we = 1; wdata = 8'h66;
    repeat (2) step();
    req = 0;
    while (cur.busy) step();

    phase = "R9";  // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = $urandom_range(0, 1) ? 16'($urandom_range(0, 255)) : 16'($urandom);
      access(1'($urandom_range(0, 3) == 0), 1'($urandom), a, 1'($urandom), 8'($urandom));
      if ($urandom_range(0, 2) == 0) step();
    end
    repeat (3) step();

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog [%s] act hung exp finished", phase);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule